// File: doc/BRIEF.md
# Edge-Triggered Hierarchical Interrupt Aggregator

This block collects interrupt events from three source groups: an engine group, a power group and a display group. Each group has a sticky pending register, which captures one-cycle event pulses, and an enable register, which decides whether pending bits reach the CPU. A global gate bit lets the engine and power groups through. The display group does not pass through this gate. All contributions are reduced to one combined level. The CPU interrupt is a single-cycle pulse that fires only when that level rises.

Because the output is edge based, a handler that leaves some bits pending could miss later interrupts. To avoid this, the handler drops the global gate and the display enable, clears what it has serviced, and then writes back the saved settings. If anything unmasked is still pending at that point, the level rises again and a new pulse follows. A single-cycle register bus gives read and write access to every register. The rst_n input is expected to be asserted asynchronously and released synchronously to clk by the reset network of the chip.

Top module: `irq_edge_aggregator`

## Requirements
- R1: An event pulse on any source bit sets the matching pending bit in the next cycle, whether or not its enable bit is set, and the bit stays set until it is cleared.
- R2: A bus write to a pending register clears exactly the bits that are 1 in the written data. All other pending bits are unchanged.
- R3: When an event and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R4: The combined level is (display pending AND display enable) OR ((engine pending AND engine enable) OR (power pending AND power enable)) gated by the global gate bit. With the gate at 0, engine and power bits produce no interrupt.
- R5: Display contributions reach the combined level whatever the value of the global gate bit.
- R6: cpu_irq is high for exactly one cycle. This happens two clock edges after the first edge at which the combined level is seen high following a cycle in which it was low.
- R7: While the combined level stays high, further events produce no further cpu_irq pulses.
- R8: If the handler drops the global gate and the display enable and then restores them while an unmasked pending bit remains, a new cpu_irq pulse follows.
- R9: Address map on bus_addr: 0 engine pending, 1 engine enable, 2 power pending, 3 power enable, 4 display pending, 5 display enable, 6 global gate. The gate is held in bit 31 of address 6 and the other bits of that address read 0. Enable registers and the gate read back the last value written.
- R10: After reset, all registers read 0 and cpu_irq is 0.
- R11: Addresses 7 and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| eng_evt | input | GRP_W | Engine group event pulses |
| pwr_evt | input | GRP_W | Power group event pulses |
| disp_evt | input | GRP_W | Display group event pulses |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | GRP_W | Write data |
| bus_rdata | output | GRP_W | Read data for bus_addr (combinational) |
| cpu_irq | output | 1 | Single-cycle CPU interrupt pulse |

## Verification
If a pending bit is lost or stuck, the register read shows it in the same cycle. The edge logic also reacts within two cycles, either with a missing pulse or with an extra one. If the gating is wrong, for example the global gate masks display or leaves engine ungated, a pulse appears where none is due, or is absent, two edges after the stimulus. A broken edge detector shows up as repeated pulses while the level is held high, or as a silent re-enable in the handler sequence. The bench runs a reference model and compares cpu_irq and the read data on every cycle, so each of these faults is caught in the cycle it first reaches a port.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NGRP     = 3;
  localparam int unsigned GRP_ENG  = 0;
  localparam int unsigned GRP_PWR  = 1;
  localparam int unsigned GRP_DISP = 2;
  localparam int unsigned GATE_ADDR = 6;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_STAT = 2'd1,
    RSEL_EN   = 2'd2,
    RSEL_GATE = 2'd3
  } rsel_kind_e;

  typedef struct packed {
    rsel_kind_e  kind;
    logic [1:0]  grp;
  } rsel_t;

  function automatic int unsigned stat_addr(input int unsigned g);
    return 2 * g;
  endfunction

  function automatic int unsigned en_addr(input int unsigned g);
    return 2 * g + 1;
  endfunction
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [NGRP-1:0]   stat_we,
  output logic [NGRP-1:0]   en_we,
  output logic              gate_we,
  output rsel_t             rsel
);
  always_comb begin
    stat_we = '0;
    en_we   = '0;
    gate_we = 1'b0;
    rsel    = '{kind: RSEL_NONE, grp: 2'd0};
    for (int unsigned g = 0; g < NGRP; g++) begin
      if (addr == ADDR_W'(stat_addr(g))) begin
        stat_we[g] = we;
        rsel       = '{kind: RSEL_STAT, grp: 2'(g)};
      end
      if (addr == ADDR_W'(en_addr(g))) begin
        en_we[g] = we;
        rsel     = '{kind: RSEL_EN, grp: 2'(g)};
      end
    end
    if (addr == ADDR_W'(GATE_ADDR)) begin
      gate_we = we;
      rsel    = '{kind: RSEL_GATE, grp: 2'd0};
    end
  end
endmodule

// File: rtl/irq_src_group.sv
module irq_src_group #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         pend
);
  logic [W-1:0] st_q, st_d, clr_mask, en_q;
  logic         st_ce;

  always_comb begin
    clr_mask = clr_we ? wdata : '0;
    // a new event overrides a same-cycle clear
    st_d     = (st_q & ~clr_mask) | evt;
    st_ce    = clr_we | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_ce) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= wdata;
    end
  end

  assign status = st_q;
  assign enable = en_q;
  assign pend   = |(st_q & en_q);
endmodule

// File: rtl/irq_edge_gen.sv
module irq_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic eng_pend,
  input  logic pwr_pend,
  input  logic disp_pend,
  input  logic gate,
  output logic level,
  output logic irq
);
  logic lvl_q, lvl_prev_q, irq_q;
  logic rise;

  always_comb begin
    level = disp_pend | ((eng_pend | pwr_pend) & gate);
    rise  = lvl_q & ~lvl_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      lvl_prev_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      lvl_q      <= level;
      lvl_prev_q <= lvl_q;
      irq_q      <= rise;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_edge_aggregator.sv
module irq_edge_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned GATE_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  eng_evt,
  input  logic [GRP_W-1:0]  pwr_evt,
  input  logic [GRP_W-1:0]  disp_evt,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [GRP_W-1:0]  bus_wdata,
  output logic [GRP_W-1:0]  bus_rdata,
  output logic              cpu_irq
);
  logic [NGRP-1:0][GRP_W-1:0] evt_all, st_all, en_all;
  logic [NGRP-1:0]            stat_we, en_we, pend;
  logic                       gate_we, gate_q, gate_d;
  logic                       lvl_comb;
  rsel_t                      rsel;

  assign evt_all[GRP_ENG]  = eng_evt;
  assign evt_all[GRP_PWR]  = pwr_evt;
  assign evt_all[GRP_DISP] = disp_evt;

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .we      (bus_we),
    .addr    (bus_addr),
    .stat_we (stat_we),
    .en_we   (en_we),
    .gate_we (gate_we),
    .rsel    (rsel)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    irq_src_group #(.W(GRP_W)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_all[g]),
      .clr_we (stat_we[g]),
      .en_we  (en_we[g]),
      .wdata  (bus_wdata),
      .status (st_all[g]),
      .enable (en_all[g]),
      .pend   (pend[g])
    );
  end

  assign gate_d = bus_wdata[GATE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (gate_we) begin
      gate_q <= gate_d;
    end
  end

  irq_edge_gen u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_pend  (pend[GRP_ENG]),
    .pwr_pend  (pend[GRP_PWR]),
    .disp_pend (pend[GRP_DISP]),
    .gate      (gate_q),
    .level     (lvl_comb),
    .irq       (cpu_irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (rsel.kind)
      RSEL_STAT: if (rsel.grp < NGRP) bus_rdata = st_all[rsel.grp];
      RSEL_EN:   if (rsel.grp < NGRP) bus_rdata = en_all[rsel.grp];
      RSEL_GATE: bus_rdata[GATE_BIT] = gate_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
#(
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned GATE_BIT = 31
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NGRP-1:0][GRP_W-1:0] evt_all,
  input logic [NGRP-1:0][GRP_W-1:0] st_all,
  input logic [NGRP-1:0][GRP_W-1:0] en_all,
  input logic                       gate_q,
  input logic                       lvl_comb,
  input logic                       cpu_irq,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [GRP_W-1:0]           bus_wdata
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(2 * g);

    assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_all[g]) |=> ((st_all[g] & $past(evt_all[g])) == $past(evt_all[g])));

    assert_clear_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == SA) |=>
        ((st_all[g] & $past(bus_wdata) & ~$past(evt_all[g])) == '0));

    // R3: event in the same cycle as a clear leaves the bit set
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == SA && |(evt_all[g] & bus_wdata)) |=>
        ((st_all[g] & $past(evt_all[g] & bus_wdata)) == $past(evt_all[g] & bus_wdata)));
  end

  assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && !(|(st_all[GRP_DISP] & en_all[GRP_DISP]))) |-> !lvl_comb);

  assert_disp_ungated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_all[GRP_DISP] & en_all[GRP_DISP])) |-> lvl_comb);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq);

  assert_pulse_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && cpu_irq) |-> ($past(lvl_comb, 2) && !$past(lvl_comb, 3)));

  assert_gate_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(GATE_ADDR)) |=> (gate_q == $past(bus_wdata[GATE_BIT])));
endmodule

bind irq_edge_aggregator irq_agg_checker #(
  .GRP_W(GRP_W), .ADDR_W(ADDR_W), .GATE_BIT(GATE_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_all   (evt_all),
  .st_all    (st_all),
  .en_all    (en_all),
  .gate_q    (gate_q),
  .lvl_comb  (lvl_comb),
  .cpu_irq   (cpu_irq),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/test_irq_edge_aggregator.sv
module test_irq_edge_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ev_e = '0, ev_p = '0, ev_d = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;

  irq_edge_aggregator i_irq_edge_aggregator (
    .clk(clk), .rst_n(rst_n),
    .eng_evt(ev_e), .pwr_evt(ev_p), .disp_evt(ev_d),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wd),
    .bus_rdata(rdata), .cpu_irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_st [3];
  logic [31:0] m_en [3];
  bit          m_gate;
  bit          hist [$];
  bit          exp_irq;

  function automatic logic [31:0] m_evt(input int g);
    return (g == 0) ? ev_e : (g == 1) ? ev_p : ev_d;
  endfunction

  function automatic bit m_level();
    bit d = |(m_st[2] & m_en[2]);
    bit o = |(m_st[0] & m_en[0]) || |(m_st[1] & m_en[1]);
    return d || (o && m_gate);
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a < 4'd6) return a[0] ? m_en[a >> 1] : m_st[a >> 1];
    if (a == 4'd6) return {m_gate, 31'b0};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin m_st[g] = '0; m_en[g] = '0; end
      m_gate = 0;
      hist = '{0, 0, 0};
      exp_irq = 0;
    end else begin
      hist.push_front(m_level());
      void'(hist.pop_back());
      exp_irq = hist[1] && !hist[2];
      for (int g = 0; g < 3; g++) begin
        logic [31:0] clr;
        clr = (we && addr == 4'(2 * g)) ? wd : 32'h0;
        m_st[g] = (m_st[g] & ~clr) | m_evt(g);
        if (we && addr == 4'(2 * g + 1)) m_en[g] = wd;
      end
      if (we && addr == 4'd6) m_gate = wd[31];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 cpu_irq vs model", {31'b0, irq}, {31'b0, exp_irq});
      chk("R9 rdata vs model", rdata, m_read(addr));
      if (irq) pulses++;
    end
  end

  task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                     input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2);
    @(negedge clk);
    #1;
    we = w; addr = a; wd = d; ev_e = e0; ev_p = e1; ev_d = e2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 4'd0, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cyc(0, a, 0, 0, 0, 0);
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk("R10 cpu_irq after reset", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 7; a++) begin
      rd(4'(a), v);
      chk("R10 register after reset", v, 32'h0);
    end

    // R1: event with enable off is captured, no interrupt
    p0 = pulses;
    cyc(0, 0, 0, 32'h8, 0, 0);
    idle(4);
    rd(4'd0, v); chk("R1 sticky pending", v, 32'h8);
    chk("R1 no pulse while disabled", 32'(pulses - p0), 0);

    // R4: enabled but gate closed -> nothing
    wr(4'd1, 32'h8);
    idle(4);
    chk("R4 gate closed blocks engine", 32'(pulses - p0), 0);
    wr(4'd6, 32'hFFFF_FFFF);
    idle(4);
    chk("R4 gate open gives one pulse", 32'(pulses - p0), 1);
    rd(4'd6, v); chk("R9 gate readback bit 31 only", v, 32'h8000_0000);
    rd(4'd1, v); chk("R9 enable readback", v, 32'h8);

    // R7: level held high, more events give no pulse
    p0 = pulses;
    cyc(0, 0, 0, 32'h8, 32'h1, 0);
    wr(4'd3, 32'h1);
    idle(5);
    chk("R7 no re-pulse while high", 32'(pulses - p0), 0);

    // R2: clear only the written bits
    cyc(0, 0, 0, 32'h20, 0, 0);
    wr(4'd0, 32'h8);
    rd(4'd0, v); chk("R2 partial clear", v, 32'h20);

    // R3: set wins over clear
    cyc(1, 4'd0, 32'h80, 32'h80, 0, 0);
    rd(4'd0, v); chk("R3 set beats clear", v, 32'hA0);

    // drain everything, gate off
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd2, 32'hFFFF_FFFF); wr(4'd6, 32'h0);
    idle(4);

    // R5: display passes with gate closed
    p0 = pulses;
    wr(4'd5, 32'h1);
    cyc(0, 0, 0, 0, 0, 32'h1);
    idle(4);
    chk("R5 display ungated", 32'(pulses - p0), 1);

    // R8: handler drop/restore with display still pending
    p0 = pulses;
    wr(4'd6, 32'h0);
    wr(4'd5, 32'h0);
    wr(4'd5, 32'h1);
    wr(4'd6, 32'h8000_0000);
    idle(4);
    chk("R8 re-arm gives new pulse", 32'(pulses - p0), 1);

    // R11: unmapped address
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd7, v); chk("R11 unmapped reads zero", v, 32'h0);
    rd(4'd5, v); chk("R11 enable untouched", v, 32'h1);
    rd(4'd4, v); chk("R11 pending untouched", v, 32'h1);

    // mixed traffic checked by the model every cycle
    for (int i = 0; i < 600; i++) begin
      logic [31:0] e0, e1, e2, d;
      logic w;
      e0 = ($urandom % 6 == 0) ? 32'(1) << ($urandom % 4) : 32'h0;
      e1 = ($urandom % 6 == 0) ? 32'(1) << ($urandom % 4) : 32'h0;
      e2 = ($urandom % 8 == 0) ? 32'(1) << ($urandom % 4) : 32'h0;
      w  = ($urandom % 3 == 0);
      d  = {$urandom % 2 == 0, 27'b0, 4'($urandom)};
      cyc(w, 4'($urandom % 9), d, e0, e1, e2);
    end
    idle(4);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule